// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block collects twenty-two level-sensitive interrupt sources and folds them onto two processor request lines: a normal request line and a fast (more urgent) request line. Sources 0 through 16 belong to the normal group and sources 17 through 21 belong to the fast group. The mapping is fixed. Each source passes through a two-flop synchronizer. It then meets its own bit in an enable mask, and the enabled bits of each group are ORed and registered onto that group's line.

No priority is encoded inside a group. When a line is raised, software reads the masked status register to see every pending enabled source of both groups at once, and chooses the service order itself. A raw status register shows the synchronized sources whatever the mask holds. A source keeps its line raised for as long as it drives its input high. The controller stores no pending state of its own, so a request goes away only when the source removes it or software disables it.

A small register port gives access to the mask and the two status registers. It has a write strobe, a 2-bit word address and a combinational read path.

Top module: `intc_two_level`

## Requirements
- R1: Source bits 0 to 16 form the normal group and drive only `irq_o`. Source bits 16 and below never affect `fiq_o`, and bits 17 to 21 never affect `irq_o`.
- R2: The fast group is formed by source bits 17 to 21 and drives only `fiq_o`. Both lines can be high in the same cycle, each decided only by its own group.
- R3: A source change is sampled at a rising edge. It appears in raw status after the second rising edge and on its group line after the third.
- R4: After reset the mask holds all zeros. While it stays zero, both lines stay low even with every source held high.
- R5: A source whose mask bit is 0 shows in raw status, reads 0 in masked status, and leaves its group line unchanged.
- R6: Suppose a mask write clears the bit of an active source and no other enabled source of that group is active. The group line is still high just after the write edge and low after the following edge.
- R7: Requests are level-sensitive. A line stays high for as long as an enabled source is held high, and it falls three edges after the last such source drops, with nothing latched.
- R8: Register map by word address: 0 is the mask (read/write), 1 is raw status, 2 is masked status (raw AND mask), and 3 reads all zeros. Status bit n corresponds to source n, and read bits above 21 are 0.
- R9: A write to address 1, 2 or 3 leaves the mask and both lines unchanged.
- R10: With several enabled sources of one group active, masked status shows all of them together. The group line stays high until the last one is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 22 | Level-sensitive interrupt sources, bit n = source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 22 | Write data (mask bits) |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |

## Verification
The bench aims at the group boundary by driving sources 16 and 17 alone. A design that put the split one bit off would raise the wrong line. It counts edges on a source's way to raw status and to the line, so an extra or missing synchronizer stage appears as a one-cycle shift. It clears a mask bit while another source of the same group is still active. A design that held stale state would keep the line high after the last enabled source is gone, and one that dropped the line too early would lose the remaining request. It also writes to the read-only addresses and checks that the mask survives, which catches a decoder that ignores the address.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      SEL_MASK   = 2'd0,
      SEL_RAW    = 2'd1,
      SEL_MASKED = 2'd2,
      SEL_NONE   = 2'd3
   } intc_sel_e;

   // bit vector of ones over [lo, hi] inside a width of 32
   function automatic logic [31:0] span_bits(input int unsigned lo, input int unsigned hi);
      logic [31:0] v;
      v = '0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i >= lo && i <= hi) v[i] = 1'b1;
      end
      return v;
   endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int unsigned WIDTH  = 22,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (WIDTH < 1) begin : g_bad_width
      $error("intc_sync: WIDTH must be at least 1");
   end
   if (STAGES == 1) begin : g_bad_stages
      $error("intc_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign dout = stage_q[STAGES-1];
   end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 22,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [NUM_SRC-1:0]    wdata_i,
   input  logic [NUM_SRC-1:0]    raw_i,
   output logic [NUM_SRC-1:0]    mask_o,
   output logic [NUM_SRC-1:0]    masked_o,
   output logic [DATA_W-1:0]     rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("intc_regs: NUM_SRC must fit in DATA_W");
   end

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] rsel;
   intc_sel_e          sel;

   assign sel = intc_sel_e'(addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q <= '0;
      else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i;
   end

   assign mask_o   = mask_q;
   assign masked_o = raw_i & mask_q;

   always_comb begin
      unique case (sel)
         SEL_MASK:   rsel = mask_q;
         SEL_RAW:    rsel = raw_i;
         SEL_MASKED: rsel = raw_i & mask_q;
         default:    rsel = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rsel};
   end else begin : g_nopad
      assign rdata_o = rsel;
   end

   // R9
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i != 2'd0) |=> $stable(mask_q));

   // R8
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == 2'd0) |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/intc_group_out.sv
module intc_group_out #(
   parameter int unsigned LO = 0,
   parameter int unsigned HI = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HI-LO:0] pend_i,
   output logic           req_o
);
   if (HI < LO) begin : g_bad_range
      $error("intc_group_out: HI must not be below LO");
   end

   logic req_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= |pend_i;
   end
   assign req_o = req_q;
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 22,
   parameter int unsigned NUM_FAST    = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_i,
   input  logic                  reg_wr_i,
   input  logic [REG_ADDR_W-1:0] reg_addr_i,
   input  logic [NUM_SRC-1:0]    reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   output logic                  irq_o,
   output logic                  fiq_o
);
   localparam int unsigned FAST_LO = NUM_SRC - NUM_FAST;
   localparam int unsigned NORM_HI = FAST_LO - 1;
   localparam logic [31:0] FAST_SPAN = span_bits(FAST_LO, NUM_SRC - 1);
   localparam logic [31:0] NORM_SPAN = span_bits(0, NORM_HI);
   localparam logic [NUM_SRC-1:0] FAST_BITS = FAST_SPAN[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] NORM_BITS = NORM_SPAN[NUM_SRC-1:0];

   if (NUM_SRC > 32 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("intc_two_level: NUM_SRC must fit in 32 bits and DATA_W");
   end
   if (NUM_FAST < 1 || NUM_FAST >= NUM_SRC) begin : g_bad_fast
      $error("intc_two_level: NUM_FAST must leave both groups non-empty");
   end

   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] masked;
   logic [1:0]         grp_req;

   intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_i),
      .dout (raw)
   );

   intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .raw_i   (raw),
      .mask_o  (mask),
      .masked_o(masked),
      .rdata_o (reg_rdata_o)
   );

   // group 0 = normal line, group 1 = fast line
   for (genvar g = 0; g < 2; g++) begin : g_grp
      localparam int unsigned LO = (g == 0) ? 0       : FAST_LO;
      localparam int unsigned HI = (g == 0) ? NORM_HI : NUM_SRC - 1;
      intc_group_out #(.LO(LO), .HI(HI)) i_out (
         .clk   (clk),
         .rst_n (rst_n),
         .pend_i(masked[HI:LO]),
         .req_o (grp_req[g])
      );
   end

   assign irq_o = grp_req[0];
   assign fiq_o = grp_req[1];

   // R4
   zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> (!irq_o && !fiq_o));

   // R1
   norm_line_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & mask & NORM_BITS) == '0) |=> !irq_o);

   // R2
   fast_line_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & mask & FAST_BITS) == '0) |=> !fiq_o);

   // R7
   fast_line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & mask & FAST_BITS) != '0) |=> fiq_o);

   // R10
   norm_line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & mask & NORM_BITS) != '0) |=> irq_o);
endmodule

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 22;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] src;
   logic          wr;
   logic [1:0]    addr;
   logic [NS-1:0] wdata;
   logic [31:0]   rdata;
   logic          irq, fiq;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intc_two_level i_intc_two_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src),
      .reg_wr_i   (wr),
      .reg_addr_i (addr),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .irq_o      (irq),
      .fiq_o      (fiq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   // write launched at a falling edge, taken at the next rising edge
   task automatic wr_reg(input logic [1:0] a, input logic [NS-1:0] d);
      wr = 1'b1; addr = a; wdata = d;
      step(1);
      wr = 1'b0;
   endtask

   task automatic quiesce();
      src = '0;
      wr_reg(2'd0, '0);
      step(4);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rst_n = 1'b0; src = '1; wr = 1'b0; addr = 2'd0; wdata = '0;
      step(3);
      rst_n = 1'b1;
      rd(2'd0, d);
      chk("R4 mask after reset", d, 32'h0);
      step(5);
      chk("R4 irq quiet with zero mask", {31'b0, irq}, 32'h0);
      chk("R4 fiq quiet with zero mask", {31'b0, fiq}, 32'h0);
      rd(2'd1, d);
      chk("R8 raw shows all sources", d, 32'h003F_FFFF);
      rd(2'd2, d);
      chk("R8 masked zero", d, 32'h0);
      quiesce();
   endtask

   task automatic t_norm_path();
      logic [31:0] d;
      wr_reg(2'd0, '1);
      src = 22'h1 << 16;
      step(1);
      rd(2'd1, d);
      chk("R3 raw not yet after one edge", d, 32'h0);
      step(1);
      rd(2'd1, d);
      chk("R3 raw after two edges", d, 32'h0001_0000);
      chk("R3 irq not yet after two edges", {31'b0, irq}, 32'h0);
      step(1);
      chk("R3 irq after three edges", {31'b0, irq}, 32'h1);
      chk("R1 source 16 leaves fiq low", {31'b0, fiq}, 32'h0);
      quiesce();
   endtask

   task automatic t_fast_path();
      wr_reg(2'd0, '1);
      src = 22'h1 << 17;
      step(3);
      chk("R2 source 17 raises fiq", {31'b0, fiq}, 32'h1);
      chk("R1 source 17 leaves irq low", {31'b0, irq}, 32'h0);
      src = (22'h1 << 17) | 22'h1;
      step(3);
      chk("R2 both lines together (irq)", {31'b0, irq}, 32'h1);
      chk("R2 both lines together (fiq)", {31'b0, fiq}, 32'h1);
      quiesce();
   endtask

   task automatic t_masked_off();
      logic [31:0] d;
      wr_reg(2'd0, ~(22'h1 << 7));
      src = 22'h1 << 7;
      step(4);
      chk("R5 disabled source irq low", {31'b0, irq}, 32'h0);
      rd(2'd1, d);
      chk("R5 disabled source in raw", d, 32'h80);
      rd(2'd2, d);
      chk("R5 disabled source masked 0", d, 32'h0);
      quiesce();
   endtask

   task automatic t_mask_clear();
      wr_reg(2'd0, '1);
      src = (22'h1 << 3) | (22'h1 << 9);
      step(3);
      chk("R6 irq high with two sources", {31'b0, irq}, 32'h1);
      wr_reg(2'd0, ~(22'h1 << 3));
      step(1);
      chk("R6 other enabled source keeps irq", {31'b0, irq}, 32'h1);
      wr_reg(2'd0, ~((22'h1 << 3) | (22'h1 << 9)));
      chk("R6 irq still high just after write edge", {31'b0, irq}, 32'h1);
      step(1);
      chk("R6 irq low one edge later", {31'b0, irq}, 32'h0);
      quiesce();
   endtask

   task automatic t_level();
      wr_reg(2'd0, '1);
      src = 22'h1 << 20;
      step(3);
      chk("R7 fiq raised", {31'b0, fiq}, 32'h1);
      step(10);
      chk("R7 fiq held while source held", {31'b0, fiq}, 32'h1);
      src = '0;
      step(2);
      chk("R7 fiq still high two edges after drop", {31'b0, fiq}, 32'h1);
      step(1);
      chk("R7 fiq low three edges after drop", {31'b0, fiq}, 32'h0);
      quiesce();
   endtask

   task automatic t_multi();
      logic [31:0] d;
      wr_reg(2'd0, '1);
      src = 22'h1 | 22'h2 | (22'h1 << 16);
      step(3);
      rd(2'd2, d);
      chk("R10 masked shows all pending", d, 32'h0001_0003);
      src = 22'h2 | (22'h1 << 16);
      step(3);
      chk("R10 irq held by remaining sources", {31'b0, irq}, 32'h1);
      src = '0;
      step(3);
      chk("R10 irq low when last removed", {31'b0, irq}, 32'h0);
      quiesce();
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr_reg(2'd0, '1);
      rd(2'd0, d);
      chk("R8 mask reads back, upper bits 0", d, 32'h003F_FFFF);
      src = '1;
      step(3);
      rd(2'd3, d);
      chk("R8 address 3 reads zero", d, 32'h0);
      quiesce();
   endtask

   task automatic t_ro_write();
      logic [31:0] d;
      wr_reg(2'd0, 22'h1 << 4);
      src = 22'h1 << 4;
      step(3);
      wr_reg(2'd1, '0);
      wr_reg(2'd2, '0);
      wr_reg(2'd3, '0);
      rd(2'd0, d);
      chk("R9 mask unchanged by read-only writes", d, 32'h10);
      step(2);
      chk("R9 irq unchanged by read-only writes", {31'b0, irq}, 32'h1);
      quiesce();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_norm_path();
      t_fast_path();
      t_masked_off();
      t_mask_clear();
      t_level();
      t_multi();
      t_regmap();
      t_ro_write();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule